// File: doc/BRIEF.md
# Key-Locked Watchdog Reset Timer

This block is a countdown watchdog for a power-management die, configured through a small 16-bit register file. Software must first write a fixed unlock key before it can change the 32-bit reload value or the control word. The reload value is split across a low half and a high half. Two gate registers, one for the module and one for its clock, must both have their enable bit set before the counter moves. Those two registers are not protected by the key.

Once started, the counter moves down by one on each pulse of a slow tick enable, nominally 32768 Hz, supplied from outside. If the count reaches zero while reset is enabled, the block raises a system reset request for a fixed number of cycles. It then drops the run bit and stays stopped until software starts it again. If software clears the run bit while the count is in progress, the count freezes where it is.

Top module: `wdt_keylock_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0 and the lock reads locked. The count is 0 and the reset request is low.
- R2: Writing 16'hE551 to the lock register (offset 0x0A0) unlocks the block. Writing any other value there re-locks it. A read of 0x0A0 returns the unlocked state in bit 0.
- R3: Each of load-low (0x080), load-high (0x084) and control (0x088) reads back its stored value. Writes to these three registers change nothing while the block is locked.
- R4: The module gate (0x0C08) and clock gate (0x0C18) registers are writable whether the block is locked or not. The count moves only while bit 2 of both gate registers is 1.
- R5: In the control register, bit 1 is run and bit 3 is reset-enable. When a write takes run from 0 to 1, the count loads {load-high, load-low} at the following clock edge.
- R6: While run and both gates are set and the count is non-zero, the count decreases by one at each edge where tick_en is high. The count is unchanged at all other edges.
- R7: When the count is 0 with run, both gates and reset-enable set, sys_rst_req rises at the next edge and stays high for exactly 4 cycles. At the edge where it falls, the run bit is cleared. A reload value of 0 therefore expires as soon as the counter is started.
- R8: When reset-enable is clear, a count that reaches 0 stays at 0. No reset request is raised, and the run bit stays set.
- R9: Clearing run while the count is in progress freezes the count and prevents any reset request. Setting run again reloads the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at the countdown rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 16 | Combinational read data |
| count | output | 32 | Current count value |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
A register write takes effect at the edge that samples it, so its readback through rd_data is valid in the same cycle after that edge. A rising run bit makes the count load one edge later. Each tick moves the count at the edge where tick_en is sampled. The reset request rises one edge after the count is seen at zero, and the run bit clears four edges after that. The bench drives inputs on falling edges and runs a behavioural model on rising edges. Shortly after each falling edge it compares count and sys_rst_req against the model. Its directed readback and pulse-length checks are taken at falling edges, placed after the edge at which the result is due.

// File: rtl/wdt_pkg.sv
// Package: register offsets, key and bit positions of the key-locked watchdog.
// Assumes 12-bit byte offsets and 16-bit registers at the top level.
package wdt_pkg;
    localparam logic [11:0] OFF_LOAD_LO = 12'h080;
    localparam logic [11:0] OFF_LOAD_HI = 12'h084;
    localparam logic [11:0] OFF_CTRL    = 12'h088;
    localparam logic [11:0] OFF_LOCK    = 12'h0A0;
    localparam int          NUM_GATES   = 2;
    localparam logic [11:0] OFF_GATE [NUM_GATES] = '{12'hC08, 12'hC18};
    localparam logic [15:0] UNLOCK_KEY  = 16'hE551;
    localparam int          BIT_RUN     = 1;
    localparam int          BIT_RSTEN   = 3;
    localparam int          BIT_GATE    = 2;
endpackage

// File: rtl/wdt_regfile.sv
// Module: register file of the watchdog. It holds the lock state, the reload
// halves, the control bits and the two gate registers, and provides a
// combinational read mux. Assumes DATA_W > BIT_RSTEN. A hardware clear of run
// takes priority over a software write in the same cycle.
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  clr_run_i,
    output logic                  run_o,
    output logic                  rst_en_o,
    output logic                  gate_o,
    output logic [2*DATA_W-1:0]   load_o
);
    logic              unlocked_q;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic              run_q, rsten_q;
    logic [DATA_W-1:0] gate_q [NUM_GATES];
    logic              hit_lock, hit_lo, hit_hi, hit_ctrl;
    logic [NUM_GATES-1:0] gate_bits;

    // Purpose: decode write strobes for the fixed registers.
    always_comb begin
        hit_lock = wr_en_i && (wr_addr_i == ADDR_W'(OFF_LOCK));
        hit_lo   = wr_en_i && (wr_addr_i == ADDR_W'(OFF_LOAD_LO));
        hit_hi   = wr_en_i && (wr_addr_i == ADDR_W'(OFF_LOAD_HI));
        hit_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(OFF_CTRL));
    end

    // Purpose: lock state, opened by the key and closed by any other value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked_q <= 1'b0;
        else if (hit_lock)
            unlocked_q <= (wr_data_i == DATA_W'(UNLOCK_KEY));
    end

    // Purpose: reload halves, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (unlocked_q) begin
            if (hit_lo) lo_q <= wr_data_i;
            if (hit_hi) hi_q <= wr_data_i;
        end
    end

    // Purpose: control bits; the end of a reset pulse clears run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            rsten_q <= 1'b0;
        end else begin
            if (hit_ctrl && unlocked_q) begin
                run_q   <= wr_data_i[BIT_RUN];
                rsten_q <= wr_data_i[BIT_RSTEN];
            end
            if (clr_run_i)
                run_q <= 1'b0;
        end
    end

    // Purpose: gate registers, one per enable, never locked.
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        always_ff @(posedge clk) begin
            if (!rst_n)
                gate_q[g] <= '0;
            else if (wr_en_i && (wr_addr_i == ADDR_W'(OFF_GATE[g])))
                gate_q[g] <= wr_data_i;
        end
        assign gate_bits[g] = gate_q[g][BIT_GATE];
    end

    // Purpose: combinational read mux over all registers.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(OFF_LOCK))    rd_data_o[0] = unlocked_q;
        if (rd_addr_i == ADDR_W'(OFF_LOAD_LO)) rd_data_o = lo_q;
        if (rd_addr_i == ADDR_W'(OFF_LOAD_HI)) rd_data_o = hi_q;
        if (rd_addr_i == ADDR_W'(OFF_CTRL)) begin
            rd_data_o[BIT_RUN]   = run_q;
            rd_data_o[BIT_RSTEN] = rsten_q;
        end
        for (int g = 0; g < NUM_GATES; g++)
            if (rd_addr_i == ADDR_W'(OFF_GATE[g])) rd_data_o = gate_q[g];
    end

    assign run_o    = run_q;
    assign rst_en_o = rsten_q;
    assign gate_o   = &gate_bits;
    assign load_o   = {hi_q, lo_q};

    // R3: a locked write leaves the reload low half untouched
    assert_locked_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo && !unlocked_q |=> $stable(lo_q));
    // R3: a locked write leaves reset-enable untouched
    assert_locked_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl && !unlocked_q |=> $stable(rsten_q));
    // R2: the key opens the lock
    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lock && (wr_data_i == DATA_W'(UNLOCK_KEY)) |=> unlocked_q);
    // R7: a hardware clear request always drops run
    assert_hw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_run_i |=> !run_q);
endmodule

// File: rtl/wdt_countdown.sv
// Module: countdown core. It reloads on a rising run, decrements on gated ticks
// and emits a fixed-length reset pulse on expiry, then asks for run to be
// cleared. Assumes tick_i is a single-cycle pulse and PULSE_LEN >= 1.
module wdt_countdown #(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             rst_en_i,
    input  logic             gate_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             rst_req_o,
    output logic             clr_run_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic             run_d1;
    logic [CNT_W-1:0] cnt_q;
    logic [PW-1:0]    pulse_q;
    logic             start, active, fire;

    // Purpose: derive start, active and expiry conditions.
    always_comb begin
        start  = run_i && !run_d1;
        active = run_i && run_d1 && gate_i;
        fire   = active && rst_en_i && (cnt_q == '0) && (pulse_q == '0);
    end

    // Purpose: delayed run for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) run_d1 <= 1'b0;
        else        run_d1 <= run_i;
    end

    // Purpose: count register with reload and gated decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= load_i;
        else if (active && tick_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Purpose: reset pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else if (pulse_q != '0)
            pulse_q <= pulse_q - 1'b1;
        else if (fire)
            pulse_q <= PW'(PULSE_LEN);
    end

    assign cnt_o     = cnt_q;
    assign rst_req_o = (pulse_q != '0);
    assign clr_run_o = (pulse_q == PW'(1));

    // R9: with run low the count holds
    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(cnt_q));
    // R9: no reset pulse starts while run is low
    assert_no_rst_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i && !rst_req_o |=> !rst_req_o);
    // R6: without a tick and outside a reload the count holds
    assert_tick_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !start |=> $stable(cnt_q));
    // R4: a closed gate holds the count outside a reload
    assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i && !start |=> $stable(cnt_q));
    // R7: the pulse starts only after a zero count with reset enabled
    assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(cnt_q) == '0) && $past(rst_en_i));
    // R7: run is already down when the pulse ends
    assert_pulse_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> !run_i);
endmodule

// File: rtl/wdt_keylock_timer.sv
// Module: top of the key-locked watchdog reset timer. It joins the register
// file to the countdown core. Assumes tick_en is synchronous to clk.
module wdt_keylock_timer #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 16,
    parameter int PULSE_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [2*DATA_W-1:0] count,
    output logic                sys_rst_req
);
    localparam int CNT_W = 2 * DATA_W;

    logic             run, rst_en, gate, clr_run;
    logic [CNT_W-1:0] load;

    wdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .clr_run_i(clr_run), .run_o(run), .rst_en_o(rst_en),
        .gate_o(gate), .load_o(load)
    );

    wdt_countdown #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run_i(run), .rst_en_i(rst_en), .gate_i(gate), .tick_i(tick_en),
        .load_i(load), .cnt_o(count), .rst_req_o(sys_rst_req),
        .clr_run_o(clr_run)
    );
endmodule

// File: tb/tb_wdt_keylock_timer.sv
module tb_wdt_keylock_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [31:0] count;
    logic        sys_rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    int rst_seen = 0;
    bit cmp_on = 0;

    // behavioural reference state
    bit          m_unl, m_run, m_ren, m_prev;
    logic [15:0] m_lo, m_hi, m_men, m_cen;
    logic [31:0] m_cnt;
    int          m_pulse;
    bit          t_gate, t_start, t_active;
    int          t_old_pulse;

    wdt_keylock_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .sys_rst_req(sys_rst_req)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_unl = 0; m_run = 0; m_ren = 0; m_prev = 0;
            m_lo = 0; m_hi = 0; m_men = 0; m_cen = 0; m_cnt = 0; m_pulse = 0;
        end else begin
            t_gate   = m_men[2] && m_cen[2];
            t_start  = m_run && !m_prev;
            t_active = m_run && m_prev && t_gate;
            t_old_pulse = m_pulse;
            if (m_pulse > 0) m_pulse = m_pulse - 1;
            else if (t_active && m_ren && m_cnt == 0) m_pulse = 4;
            if (t_start) m_cnt = {m_hi, m_lo};
            else if (t_active && tick_en && m_cnt != 0) m_cnt = m_cnt - 1;
            m_prev = m_run;
            if (wr_en) begin
                if (wr_addr == 12'h0A0) m_unl = (wr_data == 16'hE551);
                if (wr_addr == 12'hC08) m_men = wr_data;
                if (wr_addr == 12'hC18) m_cen = wr_data;
                if (m_unl_old()) begin
                    if (wr_addr == 12'h080) m_lo = wr_data;
                    if (wr_addr == 12'h084) m_hi = wr_data;
                    if (wr_addr == 12'h088) begin m_run = wr_data[1]; m_ren = wr_data[3]; end
                end
            end
            if (t_old_pulse == 1) m_run = 0;
        end
    end

    // lock state before this edge's lock write
    bit m_unl_prev = 0;
    always @(negedge clk) m_unl_prev = m_unl;
    function automatic bit m_unl_old();
        return m_unl_prev;
    endfunction

    // per-cycle comparison of count and reset request
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            #1;
            check("R6 count vs model", count, m_cnt);
            check("R7 reset request vs model", {31'b0, sys_rst_req}, {31'b0, (m_pulse > 0)});
            if (sys_rst_req) rst_seen++;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1;
            @(negedge clk); tick_en = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_rd(input string req, input logic [11:0] a, input logic [15:0] exp);
        rd_addr = a;
        #2;
        check(req, {16'b0, rd_data}, {16'b0, exp});
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1;
        cmp_on = 1;
        idle(1);
        // R1 reset state
        chk_rd("R1 lock", 12'h0A0, 16'h0000);
        chk_rd("R1 load-low", 12'h080, 16'h0000);
        chk_rd("R1 control", 12'h088, 16'h0000);
        chk_rd("R1 gate", 12'hC08, 16'h0000);
        check("R1 count", count, 32'h0);
        check("R1 reset request", {31'b0, sys_rst_req}, 32'h0);
        // R3 locked writes ignored
        wr(12'h080, 16'h1234);
        wr(12'h088, 16'h000A);
        chk_rd("R3 locked load-low", 12'h080, 16'h0000);
        chk_rd("R3 locked control", 12'h088, 16'h0000);
        // R2 unlock, relock, unlock
        wr(12'h0A0, 16'hE551);
        chk_rd("R2 unlocked", 12'h0A0, 16'h0001);
        wr(12'h080, 16'h0005);
        wr(12'h084, 16'h0000);
        chk_rd("R3 load-low readback", 12'h080, 16'h0005);
        wr(12'h0A0, 16'h1111);
        chk_rd("R2 relocked", 12'h0A0, 16'h0000);
        wr(12'h080, 16'h0009);
        chk_rd("R3 relocked load-low", 12'h080, 16'h0005);
        wr(12'h0A0, 16'hE551);
        // R4 gates writable, single gate blocks count; R5 reload
        wr(12'hC08, 16'h0004);
        chk_rd("R4 module gate", 12'hC08, 16'h0004);
        wr(12'h088, 16'h000A);
        idle(1);
        check("R5 reload", count, 32'd5);
        tick(3);
        check("R4 one gate closed", count, 32'd5);
        wr(12'hC18, 16'h0004);
        // R6/R7 countdown and expiry
        rst_seen = 0;
        tick(2);
        check("R6 after two ticks", count, 32'd3);
        tick(3);
        idle(8);
        check("R7 pulse length", rst_seen, 32'd4);
        chk_rd("R7 run cleared", 12'h088, 16'h0008);
        check("R7 count at zero", count, 32'd0);
        // R8 no reset when reset-enable clear
        wr(12'h080, 16'h0002);
        wr(12'h088, 16'h0002);
        rst_seen = 0;
        tick(3);
        idle(10);
        check("R8 no pulse", rst_seen, 32'd0);
        chk_rd("R8 run kept", 12'h088, 16'h0002);
        // R9 freeze and reload
        wr(12'h088, 16'h0000);
        wr(12'h080, 16'h0064);
        wr(12'h088, 16'h000A);
        tick(3);
        check("R9 before freeze", count, 32'd97);
        wr(12'h088, 16'h0008);
        rst_seen = 0;
        tick(5);
        check("R9 frozen", count, 32'd97);
        check("R9 no pulse", rst_seen, 32'd0);
        wr(12'h088, 16'h000A);
        idle(1);
        check("R9 reload on restart", count, 32'd100);
        // R3 locked control write ignored while running
        wr(12'h0A0, 16'h0000);
        wr(12'h088, 16'h0000);
        chk_rd("R3 locked control kept", 12'h088, 16'h000A);
        tick(1);
        check("R3 still counting", count, 32'd99);
        wr(12'h0A0, 16'hE551);
        // R7 zero reload expires immediately
        wr(12'h088, 16'h0000);
        wr(12'h080, 16'h0000);
        rst_seen = 0;
        wr(12'h088, 16'h000A);
        idle(10);
        check("R7 zero load pulse", rst_seen, 32'd4);
        // R5 high half and R6 borrow across halves
        wr(12'h084, 16'h0001);
        wr(12'h088, 16'h0002);
        idle(1);
        check("R5 high half reload", count, 32'h0001_0000);
        tick(1);
        check("R6 borrow", count, 32'h0000_FFFF);
        idle(2);
        cmp_on = 0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule